// File: doc/BRIEF.md
# APB Wait-State Completer with Error Response

This block is an APB completer that holds back every access for a fixed,
parameter-set number of wait states. It then ends the access with a 32-bit
register read, a register write, or an error. The wait count is a down-counter.
The counter reloads whenever the requester presents a setup phase. It counts
down only on cycles of the access phase. It never waits for any signal from
outside the block, so every access that reaches its access phase is sure to
finish.

Each address is classified during the setup phase. Word addresses below
`NUM_REGS` hit a small bank of registers, indexed by `paddr[IDX_W+1:2]`, and
the two lowest address bits are ignored. Every other address is unmapped. An
unmapped access completes in its first access cycle with `pslverr` high. It
never waits on the counter and never changes a register.

The controller is a four-state machine:

- `S_IDLE`: no access is in flight.
- `S_MAP_RD`: a mapped read is waiting for completion.
- `S_MAP_WR`: a mapped write is waiting for completion.
- `S_UNMAP`: an access to an unmapped address is waiting for completion.

Its transitions are:

- A setup phase in any state enters `S_MAP_RD`, `S_MAP_WR` or `S_UNMAP`, chosen by the address decode and `pwrite`.
- An access cycle with the count at zero takes `S_MAP_RD` or `S_MAP_WR` back to `S_IDLE`.
- Any access cycle takes `S_UNMAP` back to `S_IDLE`.
- In all other cases the state holds.

Top module: `apb_wait_completer`

## Requirements
- R1: After `presetn` is released, `pready` and `pslverr` are low, `prdata` is zero, and every register reads back as zero.
- R2: The wait counter loads `WAIT_INIT` on every cycle in which `psel` is high and `penable` is low.
- R3: The counter falls by one on each cycle with `psel` and `penable` high and a non-zero count. It depends on no other input.
- R4: For a mapped access, `pready` stays low for exactly `WAIT_INIT` access-phase cycles and rises in the next one. The address and direction are taken from the setup phase.
- R5: A mapped write stores `pwdata` into the register selected by `paddr[IDX_W+1:2]` in the completion cycle. Address bits 1:0 are ignored.
- R6: A mapped read returns the selected register on `prdata` in its completion cycle. `prdata` is zero in every cycle that is not the completion of a mapped read.
- R7: An unmapped access (word address `paddr[ADDR_W-1:2]` at or above `NUM_REGS`) completes in its first access-phase cycle, with `pready` and `pslverr` both high.
- R8: An unmapped read returns zero. An unmapped write leaves every register unchanged, including the register its low address bits would alias onto.
- R9: `pslverr` is high only in the completion cycle of an unmapped access, and low during wait cycles and mapped completions.
- R10: With `WAIT_INIT` = 0, a mapped access completes in its first access-phase cycle.
- R11: `pready` is a single-cycle pulse. A setup phase that immediately follows a completion starts a new access correctly.
- R12: Asserting `presetn` low during a wait aborts the access at once: `pready` falls and the registers clear. The next access behaves normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Completer select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, zero outside a mapped read completion |
| pready | output | 1 | Completion strobe |
| pslverr | output | 1 | Error flag for an unmapped access |

## Verification
The assertions assume that the requester obeys the transfer rules. Every access begins with exactly one setup cycle. Once the access phase has begun, `psel` and `penable` stay high, and `paddr` and `pwrite` stay stable, until `pready` is seen high. Two assertions check this input behaviour while an access is in flight.

The bench drives every transfer through one task that keeps to these rules. It drives inputs on the falling edge, raises `penable` one cycle after setup, and holds all bus signals until completion. The reset-during-wait case is the one planned exception: there the access is abandoned only after `presetn` is low, while every assertion is disabled.

// File: rtl/apb_wait_pkg.sv
package apb_wait_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_MAP_RD = 2'd1,
        S_MAP_WR = 2'd2,
        S_UNMAP  = 2'd3
    } acc_state_e;

endpackage

// File: rtl/apb_wait_counter.sv
module apb_wait_counter #(
    parameter int unsigned WAIT_INIT = 3,
    parameter int unsigned CNT_W     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    output logic cnt_zero
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (psel && !penable) begin
            cnt <= CNT_W'(WAIT_INIT);
        end else if (psel && penable && (cnt != '0)) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign cnt_zero = (cnt == '0);

    a_r2_load_at_setup: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable) |=> (cnt == CNT_W'(WAIT_INIT)));

    a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !cnt_zero) |=> (cnt == $past(cnt) - CNT_W'(1)));

    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!psel) |=> $stable(cnt));

endmodule

// File: rtl/apb_wait_fsm.sv
module apb_wait_fsm
    import apb_wait_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    input  logic hit,
    input  logic cnt_zero,
    output logic done,
    output logic err,
    output logic wr_en,
    output logic rd_en,
    output logic busy
);

    acc_state_e st, nxt;
    logic       setup, access;

    assign setup  = psel && !penable;
    assign access = psel && penable;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= S_IDLE;
        end else begin
            st <= nxt;
        end
    end

    always_comb begin
        nxt = st;
        if (setup) begin
            if (!hit) begin
                nxt = S_UNMAP;
            end else if (pwrite) begin
                nxt = S_MAP_WR;
            end else begin
                nxt = S_MAP_RD;
            end
        end else begin
            unique case (st)
                S_IDLE:   nxt = S_IDLE;
                S_MAP_RD: if (access && cnt_zero) nxt = S_IDLE;
                S_MAP_WR: if (access && cnt_zero) nxt = S_IDLE;
                S_UNMAP:  if (access) nxt = S_IDLE;
            endcase
        end
    end

    always_comb begin
        done  = 1'b0;
        err   = 1'b0;
        wr_en = 1'b0;
        rd_en = 1'b0;
        busy  = (st != S_IDLE);
        unique case (st)
            S_IDLE: begin
            end
            S_MAP_RD: begin
                done  = access && cnt_zero;
                rd_en = access && cnt_zero;
            end
            S_MAP_WR: begin
                done  = access && cnt_zero;
                wr_en = access && cnt_zero;
            end
            S_UNMAP: begin
                done = access;
                err  = access;
            end
        endcase
    end

    a_r4_requester_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && psel && penable && !done) |=> (psel && penable));

    a_r11_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy || $past(setup)));

endmodule

// File: rtl/apb_wait_regbank.sv
module apb_wait_regbank #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned IDX_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (we && (idx == IDX_W'(g))) begin
                regs[g] <= wdata;
            end
        end

        a_r8_untouched_reg: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && (idx == IDX_W'(g))) |=> $stable(regs[g]));

        a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (we && (idx == IDX_W'(g))) |=> (regs[g] == $past(wdata)));
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx == IDX_W'(i)) rdata = regs[i];
        end
    end

endmodule

// File: rtl/apb_wait_completer.sv
module apb_wait_completer #(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned NUM_REGS  = 8,
    parameter int unsigned WAIT_INIT = 3
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr
);

    localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int unsigned CNT_W = (WAIT_INIT > 1) ? $clog2(WAIT_INIT + 1) : 1;
    localparam logic [ADDR_W-3:0] WORDS = (ADDR_W-2)'(NUM_REGS);

    logic              hit, cnt_zero, done, err, wr_en, rd_en, busy;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] bank_rdata;
    logic              unused_lsb;

    assign unused_lsb = ^paddr[1:0];
    assign hit = (paddr[ADDR_W-1:2] < WORDS);

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            idx_q <= '0;
        end else if (psel && !penable) begin
            idx_q <= paddr[IDX_W+1:2];
        end
    end

    apb_wait_counter #(
        .WAIT_INIT (WAIT_INIT),
        .CNT_W     (CNT_W)
    ) u_counter (
        .clk      (pclk),
        .rst_n    (presetn),
        .psel     (psel),
        .penable  (penable),
        .cnt_zero (cnt_zero)
    );

    apb_wait_fsm u_fsm (
        .clk      (pclk),
        .rst_n    (presetn),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .hit      (hit),
        .cnt_zero (cnt_zero),
        .done     (done),
        .err      (err),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .busy     (busy)
    );

    apb_wait_regbank #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_regbank (
        .clk   (pclk),
        .rst_n (presetn),
        .we    (wr_en),
        .idx   (idx_q),
        .wdata (pwdata),
        .rdata (bank_rdata)
    );

    assign pready  = done;
    assign pslverr = err;
    assign prdata  = rd_en ? bank_rdata : '0;

    a_r4_addr_held: assert property (@(posedge pclk) disable iff (!presetn)
        (busy && psel && penable && !pready) |=> ($stable(paddr) && $stable(pwrite)));

    a_r6_rdata_quiet: assert property (@(posedge pclk) disable iff (!presetn)
        (!pready || pwrite) |-> (prdata == '0));

    a_r7_unmapped_fast: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && !penable && !hit) ##1 (psel && penable) |-> (pready && pslverr));

    a_r8_unmapped_rdata: assert property (@(posedge pclk) disable iff (!presetn)
        pslverr |-> (prdata == '0));

    a_r9_err_only_at_done: assert property (@(posedge pclk) disable iff (!presetn)
        pslverr |-> pready);

    a_r11_ready_pulse: assert property (@(posedge pclk) disable iff (!presetn)
        pready |=> !pready);

    if (WAIT_INIT == 0) begin : g_nowait
        a_r10_no_wait: assert property (@(posedge pclk) disable iff (!presetn)
            (psel && !penable && hit) ##1 (psel && penable) |-> pready);
    end else begin : g_wait
        a_r4_first_cycle_waits: assert property (@(posedge pclk) disable iff (!presetn)
            (psel && !penable && hit) ##1 (psel && penable) |-> !pready);
    end

endmodule

// File: tb/apb_wait_completer_bench.sv
module apb_wait_completer_bench;

    localparam int unsigned WAITS = 3;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic        exp_err;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h000, 32'hA5A5_0001, 32'h0000_0000, 1'b0},
        '{1'b1, 12'h01C, 32'h0000_BEEF, 32'h0000_0000, 1'b0},
        '{1'b1, 12'h020, 32'hDEAD_0000, 32'h0000_0000, 1'b1},
        '{1'b0, 12'h000, 32'h0000_0000, 32'hA5A5_0001, 1'b0},
        '{1'b0, 12'h01C, 32'h0000_0000, 32'h0000_BEEF, 1'b0},
        '{1'b0, 12'h020, 32'h0000_0000, 32'h0000_0000, 1'b1},
        '{1'b1, 12'h004, 32'h1234_5678, 32'h0000_0000, 1'b0},
        '{1'b0, 12'h006, 32'h0000_0000, 32'h1234_5678, 1'b0},
        '{1'b0, 12'hFFC, 32'h0000_0000, 32'h0000_0000, 1'b1},
        '{1'b0, 12'h008, 32'h0000_0000, 32'h0000_0000, 1'b0}
    };

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata, prdata_nw;
    logic        pready, pslverr, pready_nw, pslverr_nw;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 pclk = ~pclk;

    apb_wait_completer #(.WAIT_INIT(WAITS)) u_apb_wait_completer (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .pready(pready), .pslverr(pslverr)
    );

    apb_wait_completer #(.WAIT_INIT(0)) u_apb_wait_completer_nw (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata_nw), .pready(pready_nw), .pslverr(pslverr_nw)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic xfer(input logic wr, input logic [11:0] addr, input logic [31:0] wd,
                        output int waits, output logic [31:0] rd, output logic err,
                        output int mid_bad, output logic nw_rdy,
                        output logic [31:0] nw_rd, output logic nw_err);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = addr; pwdata = wd;
        @(negedge pclk);
        penable = 1'b1;
        #1;
        nw_rdy = pready_nw; nw_rd = prdata_nw; nw_err = pslverr_nw;
        waits = 0; mid_bad = 0;
        while (!pready && waits < 50) begin
            if (pslverr || prdata != '0) mid_bad++;
            @(negedge pclk);
            #1;
            waits++;
        end
        rd = prdata; err = pslverr;
    endtask

    task automatic go_idle();
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge pclk);
            cycles++;
        end
        chk(1'b0, "R4", "watchdog expired", cycles, 100000);
        finish_run();
    end

    initial begin
        int          w, mb;
        logic [31:0] rd, nrd;
        logic        er, nrdy, ner;

        repeat (3) @(negedge pclk);
        presetn = 1'b1;
        @(negedge pclk); #1;
        chk(pready == 1'b0, "R1", "pready after reset", 32'(pready), 0);
        chk(pslverr == 1'b0, "R1", "pslverr after reset", 32'(pslverr), 0);
        chk(prdata == '0, "R1", "prdata after reset", prdata, 0);
        xfer(1'b0, 12'h010, '0, w, rd, er, mb, nrdy, nrd, ner);
        chk(rd == '0, "R1", "register reset value", rd, 0);

        for (int i = 0; i < NV; i++) begin
            xfer(VECS[i].wr, VECS[i].addr, VECS[i].wdata, w, rd, er, mb, nrdy, nrd, ner);
            chk(w == (VECS[i].exp_err ? 0 : WAITS), VECS[i].exp_err ? "R7" : "R4",
                $sformatf("wait count vec %0d", i), w, VECS[i].exp_err ? 0 : WAITS);
            chk(er == VECS[i].exp_err, "R9", $sformatf("pslverr vec %0d", i),
                32'(er), 32'(VECS[i].exp_err));
            chk(rd == VECS[i].exp_rd, VECS[i].wr ? "R6" : "R5",
                $sformatf("prdata vec %0d (R8 for unmapped)", i), rd, VECS[i].exp_rd);
            chk(mb == 0, "R9", $sformatf("quiet outputs while waiting vec %0d", i), mb, 0);
            chk(nrdy == 1'b1, "R10", $sformatf("zero-wait ready vec %0d", i), 32'(nrdy), 1);
            chk(nrd == VECS[i].exp_rd && ner == VECS[i].exp_err, "R10",
                $sformatf("zero-wait data vec %0d", i), nrd, VECS[i].exp_rd);
        end

        go_idle(); #1;
        chk(pready == 1'b0, "R11", "pready dropped after completion", 32'(pready), 0);

        xfer(1'b1, 12'h018, 32'h0BAD_F00D, w, rd, er, mb, nrdy, nrd, ner);
        xfer(1'b0, 12'h018, '0, w, rd, er, mb, nrdy, nrd, ner);
        chk(rd == 32'h0BAD_F00D, "R11", "back-to-back read", rd, 32'h0BAD_F00D);
        chk(w == WAITS, "R2", "counter reloaded on back-to-back setup", w, WAITS);

        xfer(1'b1, 12'h7F0, 32'hFFFF_FFFF, w, rd, er, mb, nrdy, nrd, ner);
        xfer(1'b0, 12'h010, '0, w, rd, er, mb, nrdy, nrd, ner);
        chk(rd == '0, "R8", "aliased register untouched by unmapped write", rd, 0);
        xfer(1'b0, 12'h000, '0, w, rd, er, mb, nrdy, nrd, ner);
        chk(rd == 32'hA5A5_0001, "R8", "reg0 kept after unmapped write", rd, 32'hA5A5_0001);

        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 12'h000;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk); #1;
        chk(pready == 1'b0, "R3", "still waiting mid-count", 32'(pready), 0);
        #1 presetn = 1'b0;
        #1;
        chk(pready == 1'b0 && pslverr == 1'b0, "R12", "outputs during reset", 32'(pready), 0);
        psel = 1'b0; penable = 1'b0;
        @(negedge pclk);
        presetn = 1'b1;
        xfer(1'b0, 12'h000, '0, w, rd, er, mb, nrdy, nrd, ner);
        chk(rd == '0, "R12", "registers cleared by reset", rd, 0);
        chk(w == WAITS, "R12", "wait count after reset", w, WAITS);
        go_idle();

        repeat (2) @(negedge pclk);
        finish_run();
    end

endmodule